// File: doc/BRIEF.md
# Passcode-Guarded Control Register Block with Maskable Interrupts

This block is a small 32-bit register file for a one-time-programmable storage controller. It sits on a simple register bus (write strobe, read strobe, byte address, access size, write data) and returns read data one cycle after each read strobe. All registers other than the lock register are write-protected until software writes a specific passcode into the lock register. Any other value written there closes the guard again. Reads are never blocked.

Interrupt sources from the surrounding controller arrive as single-cycle event pulses on a 16-bit input. They set sticky bits in an interrupt status register. Software clears these bits by writing one to them. A mask register, which software can only read, decides which status bits reach the single level interrupt output. Software changes the mask through two separate registers: one clears mask bits and the other sets them. The block also holds a sticky program-lock bit, a cache-load trigger that raises a done flag in a read-only status register, and five 8-bit timing registers.

Two small state machines carry the sequential behaviour. The guard machine has the states `LK_LOCKED` (the reset state) and `LK_OPEN`. A write of the passcode to the lock register moves it to `LK_OPEN`. Any other write to the lock register moves it to `LK_LOCKED`. The cache-load machine has the states `CL_IDLE` (the reset state) and `CL_DONE`. A load request moves it from `CL_IDLE` to `CL_DONE`. It leaves `CL_DONE` only on reset.

Top module: `guarded_irq_regs`

Register map (byte offsets): 0x00 lock, 0x04 status, 0x08 interrupt status, 0x0C mask, 0x10 mask-clear, 0x14 mask-set, 0x18 cache-load, 0x1C program-lock, and timing registers 0 to 4 at 0x20, 0x24, 0x28, 0x2C and 0x30.

## Requirements
- R1: The lock register at 0x00 reads 1 after reset. A write of exactly 0x0000DF0D makes it read 0. A write of any other value makes it read 1.
- R2: While the lock register reads 1, a write to any address other than 0x00 changes no register.
- R3: Event input bit k (k = 0 to 14) sets interrupt status bit k, and event bit 15 sets status bit 31. Writing 1 to one of these status bits at 0x08 clears it. Bits 15 to 30 always read 0. A set in the same cycle as a clear wins.
- R4: The mask register at 0x0C resets to 0x80007FFF. A bus write to 0x0C has no effect.
- R5: A write to 0x10 clears the mask bits where the written data is 1. A write to 0x14 sets the mask bits where the written data is 1, limited to the implemented bits. Both addresses read 0.
- R6: The output irq is 1 exactly when some interrupt status bit is 1 and its mask bit is 0. It follows each status or mask change in the same cycle that the register updates.
- R7: The program-lock register at 0x1C keeps only bit 0. Once that bit is written to 1, it reads 1 until reset. All other bits read 0.
- R8: A write with bit 0 set to 0x18 sets bit 5 of the status register at 0x04, and the bit stays set until reset. A write with bit 0 clear does nothing. Address 0x18 reads 0.
- R9: The timing registers at 0x20, 0x24, 0x28, 0x2C and 0x30 reset to 0x19, 0xFF, 0x11, 0x3A and 0x16. Each register stores the low 8 bits of a write and reads them back zero-extended.
- R10: An access whose size code is not 2 (32-bit), or whose address is not a multiple of 4, is ignored on a write and returns 0 on a read.
- R11: A read of an address outside the map returns 0. Reads return data while the lock register reads 1.
- R12: rdata changes only on a clock edge where rd_en is high. At that edge it takes the addressed value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| size | input | 2 | Access size code: 0 byte, 1 half-word, 2 word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| src_evt | input | 16 | Interrupt event pulses: bits 0 to 14 map to status bits 0 to 14, bit 15 maps to status bit 31 |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the bus master never raises wr_en and rd_en in the same cycle. They also assume that a master writes at most one address per cycle, so the mask-clear and mask-set strobes never coincide. The bench drives every access through tasks that raise a single strobe for exactly one cycle and idle for a cycle between accesses. It pulses src_evt only in cycles with no bus write to the status register, except where a set-versus-clear case is tested on purpose. Reset is applied only at the start and once in the middle of the run, between accesses.

// File: rtl/lkrf_pkg.sv
package lkrf_pkg;
    localparam logic [31:0] UNLOCK_CODE = 32'h0000_DF0D;
    localparam logic [31:0] ISR_IMPL    = 32'h8000_7FFF;
    localparam logic [1:0]  SZ_WORD     = 2'd2;

    localparam int A_LOCK = 'h00;
    localparam int A_STAT = 'h04;
    localparam int A_ISR  = 'h08;
    localparam int A_IMR  = 'h0C;
    localparam int A_IER  = 'h10;
    localparam int A_IDR  = 'h14;
    localparam int A_CLD  = 'h18;
    localparam int A_PLK  = 'h1C;
    localparam int A_TIM0 = 'h20;
    localparam int STAT_CACHE_BIT = 5;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_LOCKED = 1'b1
    } lk_state_e;

    typedef enum logic {
        CL_IDLE = 1'b0,
        CL_DONE = 1'b1
    } cl_state_e;

    function automatic logic [31:0] evt_to_isr(input logic [15:0] e);
        return {e[15], 16'b0, e[14:0]};
    endfunction
endpackage

// File: rtl/lkrf_lock_fsm.sv
module lkrf_lock_fsm
    import lkrf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lock_we,
    input  logic [31:0] wdata,
    output logic        locked
);
    lk_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (lock_we) begin
            unique case (state_q)
                LK_LOCKED: state_d = (wdata == UNLOCK_CODE) ? LK_OPEN : LK_LOCKED;
                LK_OPEN:   state_d = (wdata == UNLOCK_CODE) ? LK_OPEN : LK_LOCKED;
            endcase
        end
    end

    always_comb begin
        locked = (state_q == LK_LOCKED);
    end

    // R1
    code_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_we && wdata == UNLOCK_CODE) |=> !locked);
    // R1
    wrong_code_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_we && wdata != UNLOCK_CODE) |=> locked);
    // R1
    guard_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_we |=> $stable(locked));
endmodule

// File: rtl/lkrf_irq_ctrl.sv
module lkrf_irq_ctrl
    import lkrf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        isr_we,
    input  logic        ier_we,
    input  logic        idr_we,
    input  logic [31:0] wdata,
    input  logic [15:0] src_evt,
    output logic [31:0] isr_q,
    output logic [31:0] imr_q,
    output logic        irq
);
    logic [31:0] evt_vec;
    logic [31:0] isr_d, imr_d;

    always_comb begin
        evt_vec = evt_to_isr(src_evt);
        isr_d   = isr_q;
        if (isr_we) isr_d = isr_d & ~wdata;
        isr_d = (isr_d | evt_vec) & ISR_IMPL;

        imr_d = imr_q;
        if (ier_we) imr_d = imr_d & ~wdata;
        if (idr_we) imr_d = (imr_d | wdata) & ISR_IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
            imr_q <= ISR_IMPL;
        end else begin
            isr_q <= isr_d;
            imr_q <= imr_d;
        end
    end

    always_comb begin
        irq = |(isr_q & ~imr_q);
    end

    // R3
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec != '0) |=> ((isr_q & $past(evt_vec)) == $past(evt_vec)));
    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_q[30:15] == '0));
    // R4
    mask_port_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ier_we && !idr_we) |=> $stable(imr_q));
    // R5
    enable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_we && !idr_we) |=> ((imr_q & $past(wdata)) == '0));
    // R5
    disable_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idr_we && !ier_we) |=> ((imr_q & $past(wdata) & ISR_IMPL) == ($past(wdata) & ISR_IMPL)));
endmodule

// File: rtl/lkrf_cfg_regs.sv
module lkrf_cfg_regs
    import lkrf_pkg::*;
#(
    parameter int NUM_TIM = 5,
    parameter int TIM_W   = 8,
    parameter logic [NUM_TIM*TIM_W-1:0] TIM_INIT = {8'h16, 8'h3A, 8'h11, 8'hFF, 8'h19}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_TIM-1:0]       tim_we,
    input  logic [TIM_W-1:0]         tim_wdata,
    input  logic                     plk_we,
    input  logic                     plk_bit,
    input  logic                     cld_we,
    input  logic                     cld_bit,
    output logic [NUM_TIM*TIM_W-1:0] tim_q,
    output logic                     plk_q,
    output logic                     cache_done
);
    cl_state_e cl_q, cl_d;

    for (genvar i = 0; i < NUM_TIM; i++) begin : g_tim
        always_ff @(posedge clk) begin
            if (!rst_n)         tim_q[i*TIM_W +: TIM_W] <= TIM_INIT[i*TIM_W +: TIM_W];
            else if (tim_we[i]) tim_q[i*TIM_W +: TIM_W] <= tim_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      plk_q <= 1'b0;
        else if (plk_we) plk_q <= plk_q | plk_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cl_q <= CL_IDLE;
        else        cl_q <= cl_d;
    end

    always_comb begin
        cl_d = cl_q;
        unique case (cl_q)
            CL_IDLE: if (cld_we && cld_bit) cl_d = CL_DONE;
            CL_DONE: cl_d = CL_DONE;
        endcase
    end

    always_comb begin
        cache_done = (cl_q == CL_DONE);
    end

    // R7
    plk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        plk_q |=> plk_q);
    // R8
    cache_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cld_we && cld_bit) |=> cache_done);
    // R8
    cache_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_done |=> cache_done);
endmodule

// File: rtl/guarded_irq_regs.sv
module guarded_irq_regs
    import lkrf_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_TIM = 5,
    parameter int TIM_W   = 8,
    parameter logic [NUM_TIM*TIM_W-1:0] TIM_INIT = {8'h16, 8'h3A, 8'h11, 8'hFF, 8'h19}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [15:0]       src_evt,
    output logic              irq
);
    logic word_ok, wr_ok, wr_open, locked;
    logic lock_we, isr_we, ier_we, idr_we, plk_we, cld_we;
    logic [NUM_TIM-1:0] tim_we;
    logic [31:0] isr_q, imr_q, rd_val, rdata_q;
    logic [NUM_TIM*TIM_W-1:0] tim_q;
    logic plk_q, cache_done;

    always_comb begin
        word_ok = (size == SZ_WORD) && (addr[1:0] == 2'b00);
        wr_ok   = wr_en && word_ok;
        wr_open = wr_ok && !locked;
        lock_we = wr_ok   && (addr == ADDR_W'(A_LOCK));
        isr_we  = wr_open && (addr == ADDR_W'(A_ISR));
        ier_we  = wr_open && (addr == ADDR_W'(A_IER));
        idr_we  = wr_open && (addr == ADDR_W'(A_IDR));
        plk_we  = wr_open && (addr == ADDR_W'(A_PLK));
        cld_we  = wr_open && (addr == ADDR_W'(A_CLD));
    end

    for (genvar i = 0; i < NUM_TIM; i++) begin : g_twe
        assign tim_we[i] = wr_open && (addr == ADDR_W'(A_TIM0 + 4 * i));
    end

    lkrf_lock_fsm u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock_we(lock_we),
        .wdata  (wdata),
        .locked (locked)
    );

    lkrf_irq_ctrl u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .isr_we (isr_we),
        .ier_we (ier_we),
        .idr_we (idr_we),
        .wdata  (wdata),
        .src_evt(src_evt),
        .isr_q  (isr_q),
        .imr_q  (imr_q),
        .irq    (irq)
    );

    lkrf_cfg_regs #(
        .NUM_TIM (NUM_TIM),
        .TIM_W   (TIM_W),
        .TIM_INIT(TIM_INIT)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .tim_we    (tim_we),
        .tim_wdata (wdata[TIM_W-1:0]),
        .plk_we    (plk_we),
        .plk_bit   (wdata[0]),
        .cld_we    (cld_we),
        .cld_bit   (wdata[0]),
        .tim_q     (tim_q),
        .plk_q     (plk_q),
        .cache_done(cache_done)
    );

    always_comb begin
        rd_val = '0;
        if (addr == ADDR_W'(A_LOCK))      rd_val = {31'b0, locked};
        else if (addr == ADDR_W'(A_STAT)) rd_val = 32'(cache_done) << STAT_CACHE_BIT;
        else if (addr == ADDR_W'(A_ISR))  rd_val = isr_q;
        else if (addr == ADDR_W'(A_IMR))  rd_val = imr_q;
        else if (addr == ADDR_W'(A_PLK))  rd_val = {31'b0, plk_q};
        for (int i = 0; i < NUM_TIM; i++) begin
            if (addr == ADDR_W'(A_TIM0 + 4 * i)) rd_val = 32'(tim_q[i*TIM_W +: TIM_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= word_ok ? rd_val : '0;
    end

    assign rdata = rdata_q;

    // R2
    locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_en && addr != ADDR_W'(A_LOCK)) |=>
        ($stable(tim_q) && $stable(plk_q) && $stable(imr_q) && $stable(cache_done)));
    // R10
    bad_size_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !word_ok) |=>
        ($stable(tim_q) && $stable(plk_q) && $stable(imr_q) && $stable(locked)));
    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/guarded_irq_regs_bench.sv
module guarded_irq_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [1:0]  size = 2'd2;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] src_evt = '0;
    logic        irq;

    int n_tests = 0, n_fail = 0;
    bit timed_out = 0;

    always #5 clk = ~clk;

    guarded_irq_regs u_guarded_irq_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .size(size), .wdata(wdata), .rdata(rdata), .src_evt(src_evt), .irq(irq)
    );

    typedef struct packed {
        logic        is_rd;
        logic [7:0]  adr;
        logic [1:0]  sz;
        logic [31:0] dat;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 40;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 2'd2, 32'h1,        4'd1},  // R1 locked after reset
        '{1'b0, 8'h20, 2'd2, 32'hAA,       4'd2},  // R2 dropped while locked
        '{1'b1, 8'h20, 2'd2, 32'h19,       4'd2},  // R2 / R11 read while locked
        '{1'b0, 8'h00, 2'd2, 32'hDF0D,     4'd1},  // R1 passcode
        '{1'b1, 8'h00, 2'd2, 32'h0,        4'd1},
        '{1'b0, 8'h20, 2'd2, 32'hAA,       4'd9},  // R9
        '{1'b1, 8'h20, 2'd2, 32'hAA,       4'd9},
        '{1'b1, 8'h24, 2'd2, 32'hFF,       4'd9},
        '{1'b1, 8'h2C, 2'd2, 32'h3A,       4'd9},
        '{1'b0, 8'h20, 2'd2, 32'h12345677, 4'd9},
        '{1'b1, 8'h20, 2'd2, 32'h77,       4'd9},
        '{1'b0, 8'h0C, 2'd2, 32'h0,        4'd4},  // R4 direct mask write
        '{1'b1, 8'h0C, 2'd2, 32'h80007FFF, 4'd4},
        '{1'b0, 8'h10, 2'd2, 32'h21,       4'd5},  // R5 mask-clear
        '{1'b1, 8'h0C, 2'd2, 32'h80007FDE, 4'd5},
        '{1'b1, 8'h10, 2'd2, 32'h0,        4'd5},
        '{1'b0, 8'h14, 2'd2, 32'h1,        4'd5},  // R5 mask-set
        '{1'b1, 8'h0C, 2'd2, 32'h80007FDF, 4'd5},
        '{1'b1, 8'h14, 2'd2, 32'h0,        4'd5},
        '{1'b0, 8'h1C, 2'd2, 32'hFFFFFFFE, 4'd7},  // R7 other bits ignored
        '{1'b1, 8'h1C, 2'd2, 32'h0,        4'd7},
        '{1'b0, 8'h1C, 2'd2, 32'h1,        4'd7},
        '{1'b0, 8'h1C, 2'd2, 32'h0,        4'd7},
        '{1'b1, 8'h1C, 2'd2, 32'h1,        4'd7},
        '{1'b0, 8'h18, 2'd2, 32'h0,        4'd8},  // R8
        '{1'b1, 8'h04, 2'd2, 32'h0,        4'd8},
        '{1'b0, 8'h18, 2'd2, 32'h1,        4'd8},
        '{1'b1, 8'h04, 2'd2, 32'h20,       4'd8},
        '{1'b1, 8'h18, 2'd2, 32'h0,        4'd8},
        '{1'b0, 8'h28, 2'd0, 32'h55,       4'd10}, // R10 byte write
        '{1'b1, 8'h28, 2'd2, 32'h11,       4'd10},
        '{1'b1, 8'h28, 2'd1, 32'h0,        4'd10},
        '{1'b1, 8'h29, 2'd2, 32'h0,        4'd10},
        '{1'b1, 8'h40, 2'd2, 32'h0,        4'd11}, // R11
        '{1'b1, 8'h3C, 2'd2, 32'h0,        4'd11},
        '{1'b0, 8'h00, 2'd2, 32'h1234,     4'd1},  // R1 relock
        '{1'b1, 8'h00, 2'd2, 32'h1,        4'd1},
        '{1'b0, 8'h2C, 2'd2, 32'h0,        4'd2},  // R2
        '{1'b1, 8'h2C, 2'd2, 32'h3A,       4'd2},
        '{1'b0, 8'h00, 2'd2, 32'hDF0D,     4'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; size = s; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a; size = s;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse_evt(input logic [15:0] e);
        @(negedge clk);
        src_evt = e;
        @(negedge clk);
        src_evt = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_all();
        logic [31:0] r;
        do_reset();
        check("reset irq", {31'b0, irq}, 32'h0);
        bus_rd(8'h08, 2'd2, r); check("R3 reset status", r, 32'h0);
        bus_rd(8'h30, 2'd2, r); check("R9 reset timing4", r, 32'h16);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_rd) begin
                bus_rd(VECS[i].adr, VECS[i].sz, r);
                check($sformatf("R%0d vec%0d", VECS[i].req, i), r, VECS[i].dat);
            end else begin
                bus_wr(VECS[i].adr, VECS[i].sz, VECS[i].dat);
            end
        end

        // R3 / R6: interrupts (block is open after the table)
        pulse_evt(16'h0008);
        bus_rd(8'h08, 2'd2, r); check("R3 event bit3", r, 32'h8);
        check("R6 masked", {31'b0, irq}, 32'h0);
        bus_wr(8'h10, 2'd2, 32'h8);
        check("R6 unmasked", {31'b0, irq}, 32'h1);
        pulse_evt(16'h8000);
        bus_rd(8'h08, 2'd2, r); check("R3 event bit15->31", r, 32'h80000008);
        bus_wr(8'h08, 2'd2, 32'h8);
        bus_rd(8'h08, 2'd2, r); check("R3 w1c", r, 32'h80000000);
        check("R6 after clear", {31'b0, irq}, 32'h0);
        bus_wr(8'h08, 2'd2, 32'h7FFF8000);
        bus_rd(8'h08, 2'd2, r); check("R3 reserved write", r, 32'h80000000);
        bus_wr(8'h10, 2'd2, 32'h80000000);
        check("R6 bit31 enabled", {31'b0, irq}, 32'h1);
        bus_wr(8'h14, 2'd2, 32'h80000000);
        check("R6 bit31 disabled", {31'b0, irq}, 32'h0);
        // R3 set wins over same-cycle clear
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h08; size = 2'd2; wdata = 32'h80000000; src_evt = 16'h8000;
        @(negedge clk);
        wr_en = 1'b0; src_evt = '0;
        bus_rd(8'h08, 2'd2, r); check("R3 set beats clear", r, 32'h80000000);
        // R2: mask-clear dropped while locked, irq unchanged
        bus_wr(8'h00, 2'd2, 32'h0);
        bus_wr(8'h10, 2'd2, 32'h80000000);
        check("R2 locked mask-clear", {31'b0, irq}, 32'h0);

        // R12: rdata holds until the read edge
        bus_rd(8'h24, 2'd2, r);
        @(negedge clk);
        rd_en = 1'b1; addr = 8'h00; size = 2'd2;
        check("R12 before edge", rdata, 32'hFF);
        @(negedge clk);
        rd_en = 1'b0;
        check("R12 after edge", rdata, 32'h1);

        // R7 / R8 / R9 cleared by reset
        do_reset();
        bus_rd(8'h1C, 2'd2, r); check("R7 reset clears", r, 32'h0);
        bus_rd(8'h04, 2'd2, r); check("R8 reset clears", r, 32'h0);
        bus_rd(8'h20, 2'd2, r); check("R9 reset timing0", r, 32'h19);
        bus_rd(8'h0C, 2'd2, r); check("R4 reset mask", r, 32'h80007FFF);
        bus_rd(8'h00, 2'd2, r); check("R1 reset lock", r, 32'h1);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        if (timed_out) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule